// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a direct-mapped cache. It keeps a small circular queue of blocks that it fetched ahead of need, in ascending block-address order. When the cache misses, it presents the missing block address on the lookup channel before going to the next memory level. Only the oldest queued entry (the head) is compared with that address.

If the head matches, the buffer hands that block to the cache on the fill channel, drops the entry, and uses the freed slot to request one more consecutive block. If the head does not match, the buffer answers with a miss so the cache fetches the block itself. It then discards every entry and starts a new stream at the block after the missed one. Data only reaches the cache when a lookup asks for it, so the cache never holds a block that has not been used.

All addresses are block addresses. The next level must answer requests in the order it accepted them, one response per cycle, and the buffer always takes a response. Every handshake channel is valid/ready. Once raised, a valid stays high with its payload unchanged until ready is seen. The buffer holds the lookup channel off (`lkp_ready` low) from the accepted lookup until its fill is taken. It also holds it off while an issued request is still waiting on `req_ready`.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset `lkp_ready` is 1, `fill_valid` is 0, and `req_valid` is 0. No prefetching happens before the first lookup.
- R2: A lookup whose block differs from the head tag (or that finds the buffer empty) gets a fill with `fill_hit`=0. After it, the next requests carry block+1, block+2 and so on, each one more than the last.
- R3: The number of requests accepted but not yet answered never exceeds DEPTH.
- R4: A lookup that matches the head gets a fill with `fill_hit`=1. The `fill_data` is what the next level returned for that block.
- R5: Each head hit frees one slot, and the buffer issues exactly one new request for the block after the newest one queued.
- R6: Only the head is compared. A lookup for a block that sits deeper in the queue is a miss and restarts the stream.
- R7: A head hit on an entry whose data has not yet returned keeps `fill_valid` low until the data arrives, then delivers it.
- R8: Responses to requests issued before a restart are discarded. They never appear as fill data for the new stream.
- R9: `req_valid`/`req_blk` and `fill_valid`/`fill_hit`/`fill_data` hold steady while their ready is low. `lkp_ready` is low while a fill is pending.
- R10: With DEPTH entries queued, no new request is made until a head hit frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Cache presents a missing block |
| lkp_ready | output | 1 | Buffer accepts the lookup |
| lkp_blk | input | AW | Block address that missed |
| fill_valid | output | 1 | Answer to the accepted lookup is available |
| fill_ready | input | 1 | Cache takes the answer |
| fill_hit | output | 1 | 1: data comes from the buffer; 0: cache must fetch itself |
| fill_data | output | DW | Block data on a hit, zero on a miss |
| req_valid | output | 1 | Prefetch request toward the next level |
| req_ready | input | 1 | Next level accepts the request |
| req_blk | output | AW | Requested block address |
| rsp_valid | input | 1 | In-order response from the next level |
| rsp_data | input | DW | Response data |

## Verification
The lookups cover several patterns. A cold miss followed by a run of consecutive hits shows that the queue refills behind each hit. A lookup for the second queued block separates head-only matching from a full associative search. A hit made right after a miss lands on an entry still waiting for data, which separates a stall from a false hit. Two misses in quick succession leave old responses in flight and show whether they are discarded or leak into the new stream. Holding back `req_ready` or `fill_ready` shows whether the outputs stay stable, and a long idle period with a full queue shows that requests stop at DEPTH.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    SB_IDLE = 1'b0,
    SB_RESP = 1'b1
  } sb_state_e;
endpackage

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_tag,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  input  logic          pop,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] pcnt,
  output logic [AW-1:0] head_tag,
  output logic [DW-1:0] head_data,
  output logic          head_pend
);
  logic [AW-1:0]    tag_mem  [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];
  logic [DEPTH-1:0] pend;
  logic [PW-1:0]    hd, tl, fp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd <= '0; tl <= '0; fp <= '0;
      cnt <= '0; pcnt <= '0; pend <= '0;
    end else if (flush) begin
      hd <= '0; tl <= '0; fp <= '0;
      cnt <= '0; pcnt <= '0; pend <= '0;
    end else begin
      if (alloc) begin
        pend[tl] <= 1'b1;
        tl       <= step(tl);
      end
      if (fill) begin
        pend[fp] <= 1'b0;
        fp       <= step(fp);
      end
      if (pop) hd <= step(hd);
      cnt  <= cnt + CW'(alloc) - CW'(pop);
      pcnt <= pcnt + CW'(alloc) - CW'(fill);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc && !flush) tag_mem[tl] <= alloc_tag;
    if (fill && !flush)  data_mem[fp] <= fill_data;
  end

  assign head_tag  = tag_mem[hd];
  assign head_data = data_mem[hd];
  assign head_pend = pend[hd];
endmodule

// File: rtl/sb_issue.sv
module sb_issue #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [AW-1:0] restart_blk,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] pcnt,
  input  logic          req_ready,
  input  logic          rsp_valid,
  output logic          req_valid,
  output logic [AW-1:0] req_blk,
  output logic          alloc,
  output logic          fill
);
  logic          armed;
  logic [CW-1:0] drop;
  logic [AW-1:0] nxt;
  logic [CW:0]   inflight;
  logic [CW:0]   drop_sum;

  assign inflight  = {1'b0, pcnt} + {1'b0, drop};
  assign req_valid = armed && (cnt < CW'(DEPTH)) && (inflight < (CW + 1)'(DEPTH));
  assign req_blk   = nxt;
  assign alloc     = req_valid && req_ready;
  assign fill      = rsp_valid && (drop == '0);
  assign drop_sum  = inflight + (CW + 1)'(alloc) - (CW + 1)'(rsp_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      drop  <= '0;
      nxt   <= '0;
    end else begin
      if (restart) begin
        armed <= 1'b1;
        drop  <= drop_sum[CW-1:0];
        nxt   <= restart_blk + 1'b1;
      end else begin
        if (rsp_valid && drop != '0) drop <= drop - 1'b1;
        if (alloc) nxt <= nxt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf #(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lkp_valid,
  output logic          lkp_ready,
  input  logic [AW-1:0] lkp_blk,
  output logic          fill_valid,
  input  logic          fill_ready,
  output logic          fill_hit,
  output logic [DW-1:0] fill_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_blk,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data
);
  import sb_pkg::*;

  sb_state_e     st;
  logic          hit_q;
  logic [CW-1:0] cnt, pcnt;
  logic [AW-1:0] head_tag;
  logic [DW-1:0] head_data;
  logic          head_pend;
  logic          alloc, fill, pop, restart;
  logic          lkp_fire, fill_fire, head_match;

  assign lkp_ready  = (st == SB_IDLE) && !(req_valid && !req_ready);
  assign lkp_fire   = lkp_valid && lkp_ready;
  assign head_match = (cnt != '0) && (head_tag == lkp_blk);
  assign restart    = lkp_fire && !head_match;
  assign fill_valid = (st == SB_RESP) && (!hit_q || !head_pend);
  assign fill_hit   = hit_q;
  assign fill_data  = hit_q ? head_data : '0;
  assign fill_fire  = fill_valid && fill_ready;
  assign pop        = fill_fire && hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SB_IDLE;
      hit_q <= 1'b0;
    end else if (st == SB_IDLE) begin
      if (lkp_fire) begin
        st    <= SB_RESP;
        hit_q <= head_match;
      end
    end else if (fill_fire) begin
      st <= SB_IDLE;
    end
  end

  sb_issue #(.AW(AW), .DEPTH(DEPTH)) u_issue (
    .clk(clk), .rst_n(rst_n), .restart(restart), .restart_blk(lkp_blk),
    .cnt(cnt), .pcnt(pcnt), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .req_valid(req_valid), .req_blk(req_blk), .alloc(alloc), .fill(fill)
  );

  sb_store #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(restart), .alloc(alloc), .alloc_tag(req_blk),
    .fill(fill), .fill_data(rsp_data), .pop(pop), .cnt(cnt), .pcnt(pcnt),
    .head_tag(head_tag), .head_data(head_data), .head_pend(head_pend)
  );
endmodule

// File: rtl/stream_prefetch_buf_chk.sv
module stream_prefetch_buf_chk #(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lkp_valid,
  input logic          lkp_ready,
  input logic [AW-1:0] lkp_blk,
  input logic          fill_valid,
  input logic          fill_ready,
  input logic          fill_hit,
  input logic [DW-1:0] fill_data,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_blk,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data
);
  logic [CW+1:0] outstanding;
  logic [AW-1:0] last_blk;
  logic          have_last;
  logic          req_fire, lkp_fire;

  assign req_fire = req_valid && req_ready;
  assign lkp_fire = lkp_valid && lkp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= '0;
      last_blk    <= '0;
      have_last   <= 1'b0;
    end else begin
      outstanding <= outstanding + (CW + 2)'(req_fire) - (CW + 2)'(rsp_valid);
      if (req_fire) last_blk <= req_blk;
      have_last <= (req_fire || have_last) && !lkp_fire;
    end
  end

  assert_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= (CW + 2)'(DEPTH));

  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && have_last) |-> (req_blk == last_blk + 1'b1));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_blk)));

  assert_fill_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_hit) && $stable(fill_data)));

  assert_lkp_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !lkp_ready);
endmodule

bind stream_prefetch_buf stream_prefetch_buf_chk #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/stream_prefetch_buf_bench.sv
module stream_prefetch_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int DEPTH = 4;
  localparam int LAT = 3;

  typedef struct packed {
    logic [15:0] blk;
    logic        hit;
    logic [7:0]  settle;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 1'b0, 8'd0},   // cold miss, R2
    '{16'h0101, 1'b1, 8'd0},   // R4 (may stall, R7)
    '{16'h0102, 1'b1, 8'd0},
    '{16'h0103, 1'b1, 8'd0},
    '{16'h0104, 1'b1, 8'd0},
    '{16'h0105, 1'b1, 8'd0},   // only present through R5 refill
    '{16'h0200, 1'b0, 8'd20},
    '{16'h0201, 1'b1, 8'd0},
    '{16'h0203, 1'b0, 8'd0},   // second entry, not head: R6
    '{16'h0204, 1'b1, 8'd12}   // new stream data, R8
  };

  logic clk = 1'b0;
  logic rst_n;
  logic lkp_valid, lkp_ready, fill_valid, fill_ready, fill_hit;
  logic req_valid, req_ready, rsp_valid;
  logic [AW-1:0] lkp_blk, req_blk;
  logic [DW-1:0] fill_data, rsp_data;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit rq_stall = 0;
  int outst = 0, max_out = 0;
  logic [AW-1:0] q_blk[$];
  int            q_due[$];
  logic [AW-1:0] rlog[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stream_prefetch_buf #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_stream_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_ready(lkp_ready),
    .lkp_blk(lkp_blk), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_hit(fill_hit), .fill_data(fill_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_blk(req_blk), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] b);
    return {~b, b};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // in-order next level with fixed latency
  initial begin
    rsp_valid = 1'b0; rsp_data = '0; req_ready = 1'b1;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rst_n) begin
        if (q_blk.size() > 0 && cyc >= q_due[0]) begin
          rsp_valid = 1'b1;
          rsp_data  = pat(q_blk[0]);
          void'(q_blk.pop_front());
          void'(q_due.pop_front());
          outst--;
        end
        req_ready = !rq_stall;
        if (req_valid && req_ready) begin
          q_blk.push_back(req_blk);
          q_due.push_back(cyc + LAT);
          rlog.push_back(req_blk);
          outst++;
          if (outst > max_out) max_out = outst;
        end
      end
    end
  end

  task automatic lookup(input logic [AW-1:0] a, input int hold,
                        output logic h, output logic [DW-1:0] d, output int w);
    @(negedge clk); #1;
    fill_ready = (hold == 0);
    lkp_valid = 1'b1; lkp_blk = a;
    while (!lkp_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    lkp_valid = 1'b0;
    w = 0;
    @(negedge clk); #1;
    while (!fill_valid) begin w++; @(negedge clk); #1; end
    h = fill_hit; d = fill_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk); #1;
      chk(fill_valid && !lkp_ready && fill_data == d && fill_hit == h,
          "R9", "fill hold", {fill_valid, lkp_ready}, 32'h2);
    end
    fill_ready = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic h;
    logic [DW-1:0] d;
    int w, n0;
    rst_n = 1'b0; lkp_valid = 1'b0; lkp_blk = '0; fill_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(lkp_ready == 1'b1, "R1", "lkp_ready", lkp_ready, 1);
    chk(fill_valid == 1'b0, "R1", "fill_valid", fill_valid, 0);
    repeat (3) @(negedge clk); #1;
    chk(req_valid == 1'b0, "R1", "req_valid idle", req_valid, 0);

    for (int i = 0; i < NV; i++) begin
      repeat (int'(VECS[i].settle)) @(posedge clk);
      lookup(VECS[i].blk, 0, h, d, w);
      chk(h == VECS[i].hit, VECS[i].hit ? "R4" : "R2", "hit flag", h, VECS[i].hit);
      if (VECS[i].hit) chk(d == pat(VECS[i].blk), "R4", "hit data", d, pat(VECS[i].blk));
    end

    // R2 / R10: a fresh stream stops at DEPTH requests
    repeat (20) @(posedge clk);
    n0 = rlog.size();
    lookup(16'h0300, 0, h, d, w);
    chk(h == 1'b0, "R2", "miss flag", h, 0);
    repeat (40) @(posedge clk);
    chk(rlog.size() - n0 == DEPTH, "R10", "requests while full", rlog.size() - n0, DEPTH);
    for (int k = 0; k < DEPTH; k++)
      if (n0 + k < rlog.size())
        chk(rlog[n0 + k] == 16'h0301 + k, "R2", "request order", rlog[n0 + k], 16'h0301 + k);

    // R5: one hit, one more request for the next block
    n0 = rlog.size();
    lookup(16'h0301, 0, h, d, w);
    chk(h && d == pat(16'h0301), "R4", "hit 0301", d, pat(16'h0301));
    repeat (20) @(posedge clk);
    chk(rlog.size() - n0 == 1, "R5", "refill count", rlog.size() - n0, 1);
    if (rlog.size() > n0) chk(rlog[n0] == 16'h0305, "R5", "refill block", rlog[n0], 16'h0305);

    // R7: hit on an entry still waiting for data
    repeat (20) @(posedge clk);
    lookup(16'h0400, 0, h, d, w);
    lookup(16'h0401, 0, h, d, w);
    chk(h == 1'b1, "R7", "pending hit flag", h, 1);
    chk(w > 0, "R7", "stall cycles", w, 1);
    chk(d == pat(16'h0401), "R7", "pending hit data", d, pat(16'h0401));

    // R8: stale responses after a quick second restart
    repeat (20) @(posedge clk);
    lookup(16'h0500, 0, h, d, w);
    lookup(16'h0600, 0, h, d, w);
    chk(h == 1'b0, "R6", "restart miss", h, 0);
    lookup(16'h0601, 0, h, d, w);
    chk(h == 1'b1 && d == pat(16'h0601), "R8", "new stream data", d, pat(16'h0601));

    // R9: request held under back-pressure
    repeat (20) @(posedge clk);
    rq_stall = 1'b1;
    lookup(16'h0700, 0, h, d, w);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(req_valid && req_blk == 16'h0701, "R9", "request hold", req_blk, 16'h0701);
      chk(lkp_ready == 1'b0, "R9", "lookup blocked", lkp_ready, 0);
    end
    rq_stall = 1'b0;
    repeat (3) @(posedge clk);
    lookup(16'h0701, 0, h, d, w);
    chk(h && d == pat(16'h0701), "R4", "hit after stall", d, pat(16'h0701));

    // R9: fill held while the cache is not ready
    repeat (10) @(posedge clk);
    lookup(16'h0702, 3, h, d, w);
    chk(h && d == pat(16'h0702), "R4", "held hit data", d, pat(16'h0702));

    chk(max_out <= DEPTH && max_out > 0, "R3", "max outstanding", max_out, DEPTH);
    finish_run();
  end
endmodule